// File: doc/BRIEF.md
# FIFO Serial Port Control and Status Registers

This block is the register front end of a FIFO-based serial port. Software reaches it over a simple single-cycle register bus whose offsets step by 4 bytes. It holds the mode, baud divisor, control, FIFO control and port registers, each with its own write mask. It also keeps five sticky status flags. Software clears a flag by writing 0 to its bit in the status register. Writing 1 to a bit leaves that flag alone.

The transmitter, the receive FIFO and the line receiver sit outside this block. A write to the transmit data offset hands a byte to the transmitter with a one-cycle strobe. Reads of the receive data offset pop the external FIFO. The line side reports break, receive-full and data-ready events through single-cycle set pulses. The block drives two interrupt lines. The transmit interrupt follows a control bit. The receive interrupt is raised by receive-full events and dropped by software.

Top module: `sfifo_csr`

## Requirements
- R1: After reset: mode 0x00, baud 0xFF, control 0x20, port 0x00, FIFO control 0x0000, status 0x60 (both transmit flags set), and `tx_irq`, `rx_irq` and `tx_strobe` low.
- R2: Register offsets are 0x00 mode, 0x04 baud, 0x08 control, 0x0C transmit data, 0x10 status, 0x14 receive data, 0x18 FIFO control, 0x1C receive count, 0x20 port and 0x24 line status. Writes store mode AND 0x7B, control AND 0xFA and port AND 0xF3. Baud is stored as 8 bits and FIFO control as all 16 bits. Each of these reads back as stored.
- R3: A read returns its data on `bus_rdata` in the cycle after the access. Status bit positions are 6 transmit end, 5 transmit empty, 4 break, 1 receive full and 0 data ready. All other status bits read 0.
- R4: A status write clears each of the five flags whose bit is written 0 and keeps each flag whose bit is written 1.
- R5: A status read returns the flags as they were before the read. After the read, if control bit 5 (transmit enable) is 1, the transmit-empty and transmit-end flags are set. If that bit is 0, the read changes nothing.
- R6: A control write with bit 5 at 0 sets the transmit-end flag. `tx_irq` equals control bit 7.
- R7: A `rxfull_det` pulse raises `rx_irq` when control bit 6 is 1, and has no effect on `rx_irq` otherwise. `rx_irq` is dropped by a control write with bit 6 at 0, or by a status write with bit 1 or bit 0 at 0. A drop wins over a simultaneous raise.
- R8: A transmit data write gives a one-cycle `tx_strobe` in the next cycle, with `tx_byte` equal to the low byte written, and clears the transmit-empty flag.
- R9: Pulses on `brk_det`, `rxfull_det` and `rdy_det` set the break, receive-full and data-ready flags. A set pulse wins over a status write that clears the same flag in that cycle.
- R10: A read of 0x14 returns `rxq_data` and gives a one-cycle `rxq_pop`. A read of 0x1C returns `rxq_count`. Reads of 0x24 and of every offset from 0x28 upward return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset; low two bits ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| tx_strobe | output | 1 | Byte handed to transmitter |
| tx_byte | output | 8 | Byte for transmitter |
| rxq_data | input | 8 | Head byte of the external receive FIFO |
| rxq_count | input | CNT_W | Fill level of the external receive FIFO |
| rxq_pop | output | 1 | Pop the receive FIFO |
| brk_det | input | 1 | Break-detected set pulse |
| rxfull_det | input | 1 | Receive-full set pulse |
| rdy_det | input | 1 | Data-ready set pulse |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Every result of this block shows up one register stage after its cause. This covers read data, `rxq_pop`, `tx_strobe` with `tx_byte`, both interrupt lines, and flag changes made by writes, reads or set pulses. The bench drives each access or pulse half a cycle before a rising edge and samples on the falling edge right after it. That sample point is exactly one cycle later. Status side effects of a read are therefore checked with a second read: the first read returns the flags from before the re-arm, and the second shows the flags after it. The absence of a strobe is checked one idle cycle later.

// File: rtl/sfcsr_pkg.sv
package sfcsr_pkg;
  // register index = byte offset / 4
  localparam logic [3:0] RG_MODE = 4'd0;
  localparam logic [3:0] RG_BAUD = 4'd1;
  localparam logic [3:0] RG_CTRL = 4'd2;
  localparam logic [3:0] RG_TXD  = 4'd3;
  localparam logic [3:0] RG_STAT = 4'd4;
  localparam logic [3:0] RG_RXD  = 4'd5;
  localparam logic [3:0] RG_FCTL = 4'd6;
  localparam logic [3:0] RG_CNT  = 4'd7;
  localparam logic [3:0] RG_PORT = 4'd8;
  localparam logic [3:0] RG_LINE = 4'd9;

  // status flag positions
  localparam int F_TEND = 6;
  localparam int F_TDE  = 5;
  localparam int F_BRK  = 4;
  localparam int F_RDF  = 1;
  localparam int F_DR   = 0;
  localparam logic [7:0] FLAG_MASK = 8'h73;

  // control bit positions
  localparam int C_TIRQ = 7;
  localparam int C_RIRQ = 6;
  localparam int C_TXEN = 5;

  localparam logic [7:0] MODE_MASK = 8'h7B;
  localparam logic [7:0] CTRL_MASK = 8'hFA;
  localparam logic [7:0] PORT_MASK = 8'hF3;
  localparam logic [7:0] CTRL_RST  = 8'h20;
  localparam logic [7:0] BAUD_RST  = 8'hFF;
  localparam logic [7:0] STAT_RST  = 8'h60;
endpackage

// File: rtl/sfcsr_mreg.sv
module sfcsr_mreg #(
  parameter int          W    = 8,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = wd & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/sfcsr_status.sv
module sfcsr_status
  import sfcsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_we,
  input  logic       stat_re,
  input  logic [7:0] stat_wd,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wd,
  input  logic [7:0] ctrl_q,
  input  logic       txd_we,
  input  logic       brk_det,
  input  logic       rxfull_det,
  input  logic       rdy_det,
  output logic [7:0] flags,
  output logic       rx_irq
);
  logic [7:0] flags_nxt;
  logic       rx_irq_nxt;

  always_comb begin
    flags_nxt = flags;
    if (stat_we) flags_nxt = flags_nxt & (stat_wd | ~FLAG_MASK);
    if (stat_re && ctrl_q[C_TXEN]) begin
      flags_nxt[F_TDE]  = 1'b1;
      flags_nxt[F_TEND] = 1'b1;
    end
    if (ctrl_we && !ctrl_wd[C_TXEN]) flags_nxt[F_TEND] = 1'b1;
    if (txd_we) flags_nxt[F_TDE] = 1'b0;
    // line events win over a clearing write
    if (brk_det)    flags_nxt[F_BRK] = 1'b1;
    if (rxfull_det) flags_nxt[F_RDF] = 1'b1;
    if (rdy_det)    flags_nxt[F_DR]  = 1'b1;
  end

  always_comb begin
    rx_irq_nxt = rx_irq;
    if (rxfull_det && ctrl_q[C_RIRQ]) rx_irq_nxt = 1'b1;
    if (ctrl_we && !ctrl_wd[C_RIRQ]) rx_irq_nxt = 1'b0;
    if (stat_we && (!stat_wd[F_RDF] || !stat_wd[F_DR])) rx_irq_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= STAT_RST;
      rx_irq <= 1'b0;
    end else begin
      flags  <= flags_nxt;
      rx_irq <= rx_irq_nxt;
    end
  end
endmodule

// File: rtl/sfifo_csr.sv
module sfifo_csr
  import sfcsr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_strobe,
  output logic [7:0]        tx_byte,
  input  logic [7:0]        rxq_data,
  input  logic [CNT_W-1:0]  rxq_count,
  output logic              rxq_pop,
  input  logic              brk_det,
  input  logic              rxfull_det,
  input  logic              rdy_det,
  output logic              tx_irq,
  output logic              rx_irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              wr_en, rd_en;
  logic              mode_we, baud_we, ctrl_we, txd_we, stat_we, fctl_we, port_we;
  logic              stat_re, rxd_re;
  logic [7:0]        wd8;
  logic [7:0]        mode_q, baud_q, ctrl_q, port_q, flags;
  logic [DATA_W-1:0] fctl_q;
  logic [DATA_W-1:0] rd_nxt;
  logic [DATA_W-1:0] rdata_q;
  logic              tx_strobe_q, rxq_pop_q;
  logic [7:0]        tx_byte_q, tx_byte_nxt;

  assign idx   = bus_addr[ADDR_W-1:2];
  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;
  assign wd8   = bus_wdata[7:0];

  assign mode_we = wr_en && (idx == IDX_W'(RG_MODE));
  assign baud_we = wr_en && (idx == IDX_W'(RG_BAUD));
  assign ctrl_we = wr_en && (idx == IDX_W'(RG_CTRL));
  assign txd_we  = wr_en && (idx == IDX_W'(RG_TXD));
  assign stat_we = wr_en && (idx == IDX_W'(RG_STAT));
  assign fctl_we = wr_en && (idx == IDX_W'(RG_FCTL));
  assign port_we = wr_en && (idx == IDX_W'(RG_PORT));
  assign stat_re = rd_en && (idx == IDX_W'(RG_STAT));
  assign rxd_re  = rd_en && (idx == IDX_W'(RG_RXD));

  sfcsr_mreg #(.W(8), .MASK(MODE_MASK), .RST(8'h00)) u_mode (
    .clk(clk), .rst_n(rst_n), .we(mode_we), .wd(wd8), .q(mode_q));
  sfcsr_mreg #(.W(8), .MASK(8'hFF), .RST(BAUD_RST)) u_baud (
    .clk(clk), .rst_n(rst_n), .we(baud_we), .wd(wd8), .q(baud_q));
  sfcsr_mreg #(.W(8), .MASK(CTRL_MASK), .RST(CTRL_RST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wd(wd8), .q(ctrl_q));
  sfcsr_mreg #(.W(8), .MASK(PORT_MASK), .RST(8'h00)) u_port (
    .clk(clk), .rst_n(rst_n), .we(port_we), .wd(wd8), .q(port_q));
  sfcsr_mreg #(.W(DATA_W), .MASK({DATA_W{1'b1}}), .RST({DATA_W{1'b0}})) u_fctl (
    .clk(clk), .rst_n(rst_n), .we(fctl_we), .wd(bus_wdata), .q(fctl_q));

  sfcsr_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .stat_we(stat_we), .stat_re(stat_re), .stat_wd(wd8),
    .ctrl_we(ctrl_we), .ctrl_wd(wd8), .ctrl_q(ctrl_q),
    .txd_we(txd_we),
    .brk_det(brk_det), .rxfull_det(rxfull_det), .rdy_det(rdy_det),
    .flags(flags), .rx_irq(rx_irq));

  always_comb begin
    rd_nxt = '0;
    case (idx)
      IDX_W'(RG_MODE): rd_nxt = DATA_W'(mode_q);
      IDX_W'(RG_BAUD): rd_nxt = DATA_W'(baud_q);
      IDX_W'(RG_CTRL): rd_nxt = DATA_W'(ctrl_q);
      IDX_W'(RG_STAT): rd_nxt = DATA_W'(flags);
      IDX_W'(RG_RXD):  rd_nxt = DATA_W'(rxq_data);
      IDX_W'(RG_FCTL): rd_nxt = fctl_q;
      IDX_W'(RG_CNT):  rd_nxt = DATA_W'(rxq_count);
      IDX_W'(RG_PORT): rd_nxt = DATA_W'(port_q);
      default:         rd_nxt = '0;
    endcase
  end

  always_comb begin
    tx_byte_nxt = tx_byte_q;
    if (txd_we) tx_byte_nxt = wd8;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q     <= '0;
      tx_strobe_q <= 1'b0;
      tx_byte_q   <= '0;
      rxq_pop_q   <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rd_nxt;
      tx_strobe_q <= txd_we;
      tx_byte_q   <= tx_byte_nxt;
      rxq_pop_q   <= rxd_re;
    end
  end

  assign bus_rdata = rdata_q;
  assign tx_strobe = tx_strobe_q;
  assign tx_byte   = tx_byte_q;
  assign rxq_pop   = rxq_pop_q;
  assign tx_irq    = ctrl_q[C_TIRQ];
endmodule

// File: rtl/sfcsr_chk.sv
module sfcsr_chk
  import sfcsr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              tx_strobe,
  input logic [7:0]        tx_byte,
  input logic              tx_irq,
  input logic              rx_irq,
  input logic              brk_det,
  input logic [7:0]        flags,
  input logic [7:0]        ctrl_q
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] ix;
  assign ix = bus_addr[ADDR_W-1:2];

  a_r4_tend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && ix == IDX_W'(RG_STAT) && !bus_wdata[F_TEND]) |=> !flags[F_TEND]);

  a_r5_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && ix == IDX_W'(RG_STAT) && ctrl_q[C_TXEN]) |=> (flags[F_TDE] && flags[F_TEND]));

  a_r6_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && ix == IDX_W'(RG_CTRL)) |=> (tx_irq == $past(bus_wdata[C_TIRQ])));

  a_r7_rx_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && ix == IDX_W'(RG_CTRL) && !bus_wdata[C_RIRQ]) |=> !rx_irq);

  a_r8_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && ix == IDX_W'(RG_TXD)) |=> (tx_strobe && tx_byte == $past(bus_wdata[7:0])));

  a_r9_brk_set: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |=> flags[F_BRK]);

  a_r10_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && ix > IDX_W'(RG_LINE)) |=> (bus_rdata == '0));
endmodule

bind sfifo_csr sfcsr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .tx_strobe(tx_strobe), .tx_byte(tx_byte), .tx_irq(tx_irq), .rx_irq(rx_irq),
  .brk_det(brk_det), .flags(flags), .ctrl_q(ctrl_q));

// File: tb/sim_sfifo_csr.sv
`timescale 1ns/1ps
module sim_sfifo_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tx_strobe, rxq_pop, tx_irq, rx_irq;
  logic [7:0]  tx_byte;
  logic [7:0]  rxq_data = 8'h00;
  logic [4:0]  rxq_count = 5'd0;
  logic        brk_det = 1'b0, rxfull_det = 1'b0, rdy_det = 1'b0;
  int checks = 0, failures = 0;
  logic [15:0] rv;

  always #2.5 clk = ~clk;

  sfifo_csr u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .rxq_data(rxq_data),
    .rxq_count(rxq_count), .rxq_pop(rxq_pop), .brk_det(brk_det),
    .rxfull_det(rxfull_det), .rdy_det(rdy_det), .tx_irq(tx_irq), .rx_irq(rx_irq));

  typedef struct packed {
    logic [5:0]  a;
    logic [15:0] d;
    logic [15:0] e;
  } vec_t;
  // write d to a, read back a, expect e (R2)
  localparam vec_t VECS [6] = '{
    '{a: 6'h00, d: 16'h00FF, e: 16'h007B},
    '{a: 6'h00, d: 16'h0084, e: 16'h0000},
    '{a: 6'h04, d: 16'h0012, e: 16'h0012},
    '{a: 6'h20, d: 16'h00FF, e: 16'h00F3},
    '{a: 6'h18, d: 16'hBEEF, e: 16'hBEEF},
    '{a: 6'h08, d: 16'h00FF, e: 16'h00FA}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] r);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    r = bus_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) brk_det = 1'b1;
    if (which == 1) rxfull_det = 1'b1;
    if (which == 2) rdy_det = 1'b1;
    @(posedge clk);
    @(negedge clk);
    brk_det = 1'b0; rxfull_det = 1'b0; rdy_det = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 tx_irq", {15'd0, tx_irq}, 16'd0);
    check("R1 rx_irq", {15'd0, rx_irq}, 16'd0);
    check("R1 tx_strobe", {15'd0, tx_strobe}, 16'd0);
    rd(6'h00, rv); check("R1 mode", rv, 16'h0000);
    rd(6'h04, rv); check("R1 baud", rv, 16'h00FF);
    rd(6'h08, rv); check("R1 ctrl", rv, 16'h0020);
    rd(6'h20, rv); check("R1 port", rv, 16'h0000);
    rd(6'h18, rv); check("R1 fctl", rv, 16'h0000);
    rd(6'h10, rv); check("R1 status", rv, 16'h0060);

    // R2 vector table
    for (int i = 0; i < 6; i++) begin
      wr(VECS[i].a, VECS[i].d);
      rd(VECS[i].a, rv);
      check("R2 masked write", rv, VECS[i].e);
    end
    check("R6 tx_irq after ctrl FF", {15'd0, tx_irq}, 16'd1);
    wr(6'h08, 16'h0020);

    // R9 / R3 set pulses and bit positions
    pulse(0); pulse(1); pulse(2);
    check("R7 no rx_irq when disabled", {15'd0, rx_irq}, 16'd0);
    rd(6'h10, rv); check("R3 status bits", rv, 16'h0073);

    // R4 write-zero clear
    wr(6'h10, 16'h00EF); rd(6'h10, rv); check("R4 clear brk", rv, 16'h0063);
    wr(6'h10, 16'h007D); rd(6'h10, rv); check("R4 clear rdf", rv, 16'h0061);
    wr(6'h10, 16'h0000); rd(6'h10, rv); check("R4 clear all", rv, 16'h0000);
    rd(6'h10, rv); check("R5 rearm on read", rv, 16'h0060);

    // R5 no rearm with transmit disabled; R6 tend set by ctrl write
    wr(6'h08, 16'h0000);
    wr(6'h10, 16'h0000);
    rd(6'h10, rv); check("R5 first read", rv, 16'h0000);
    rd(6'h10, rv); check("R5 no rearm", rv, 16'h0000);
    wr(6'h08, 16'h0000);
    rd(6'h10, rv); check("R6 tend set", rv, 16'h0040);

    // R8 transmit data
    wr(6'h08, 16'h0020);
    rd(6'h10, rv); check("R5 pre-read value", rv, 16'h0040);
    rd(6'h10, rv); check("R5 post-read value", rv, 16'h0060);
    wr(6'h0C, 16'h12A5);
    check("R8 strobe", {15'd0, tx_strobe}, 16'd1);
    check("R8 byte", {8'd0, tx_byte}, 16'h00A5);
    @(posedge clk); @(negedge clk);
    check("R8 strobe one cycle", {15'd0, tx_strobe}, 16'd0);
    rd(6'h10, rv); check("R8 tde cleared", rv, 16'h0040);

    // R6 transmit interrupt
    wr(6'h08, 16'h00A0); check("R6 tx_irq on", {15'd0, tx_irq}, 16'd1);
    wr(6'h08, 16'h0020); check("R6 tx_irq off", {15'd0, tx_irq}, 16'd0);

    // R7 receive interrupt
    wr(6'h08, 16'h0060);
    pulse(1); check("R7 raise", {15'd0, rx_irq}, 16'd1);
    wr(6'h10, 16'h00FF); check("R7 keep on ones", {15'd0, rx_irq}, 16'd1);
    wr(6'h10, 16'h00FE); check("R7 drop by status", {15'd0, rx_irq}, 16'd0);
    pulse(1); check("R7 raise again", {15'd0, rx_irq}, 16'd1);
    wr(6'h08, 16'h0020); check("R7 drop by ctrl", {15'd0, rx_irq}, 16'd0);
    pulse(1); check("R7 ignored when disabled", {15'd0, rx_irq}, 16'd0);

    // R9 set beats simultaneous clear
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h10; bus_wdata = 16'h0000; brk_det = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; brk_det = 1'b0;
    rd(6'h10, rv); check("R9 set wins", rv, 16'h0010);

    // R10 receive side and unimplemented offsets
    rxq_data = 8'h5A; rxq_count = 5'd7;
    rd(6'h14, rv); check("R10 rx data", rv, 16'h005A);
    check("R10 pop", {15'd0, rxq_pop}, 16'd1);
    rd(6'h1C, rv); check("R10 count", rv, 16'h0007);
    check("R10 no pop", {15'd0, rxq_pop}, 16'd0);
    rd(6'h24, rv); check("R10 line status", rv, 16'h0000);
    rd(6'h28, rv); check("R10 unimpl 28", rv, 16'h0000);
    rd(6'h3C, rv); check("R10 unimpl 3C", rv, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule